// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Request Arbitration

This block steps an 8-bit register-file processor through its machine cycles. Each cycle is one of four kinds: instruction fetch, instruction execute, a DMA byte transfer, or an interrupt acknowledge. The sequencer emits two timing pulses in every cycle. The early pulse marks the point where the two-bit cycle code is valid, and the late pulse is the point where requests are sampled. Instruction decode supplies a few hints: a memory read during execute, an idle command, and register loads. The sequencer owns the designator registers X and P, the save register T, the master interrupt enable and the DMA pointer R0.

DMA and interrupt requests are taken only at fixed sampling points and only once the current instruction has finished. The block settles competing requests by fixed priority. An interrupt costs one acknowledge cycle. That cycle saves the designators, forces them to fixed values and disables further interrupts. Each DMA cycle moves one byte at the address held in R0 and then advances R0. An idle command stops the cycle engine until a DMA request or an interrupt request wakes it.

Top module: `cycle_sequencer`

## Requirements
- R1: Every machine cycle lasts CYC_CLKS clocks (default 8), numbered from 0. `tpa` is high only in clock TPA_AT (default 1) and `tpb` only in clock TPB_AT (default 6). So `tpb` rises 5 clocks after `tpa` and `tpa` rises 3 clocks after `tpb`.
- R2: `state_code` is 0 for fetch, 1 for execute, 2 for DMA and 3 for interrupt acknowledge. It is valid at `tpa` and changes only at a cycle boundary.
- R3: A fetch cycle is always followed by an execute cycle. No request is serviced between the two.
- R4: `dma_in_req` and `dma_out_req` are sampled only at `tpb` of execute, DMA and acknowledge cycles. `int_req` is sampled only at `tpb` of execute and DMA cycles, and it has effect only while `mie` is 1. A level present only outside these points is ignored.
- R5: At the end of an execute, DMA or acknowledge cycle, the sampled requests are served in this order: DMA-in (DMA cycle, `dma_dir`=1), then DMA-out (DMA cycle, `dma_dir`=0), then interrupt (acknowledge cycle). If nothing is sampled, the next cycle is a fetch.
- R6: The interrupt request is not held internally. If it is gone at `tpb` of the last DMA cycle, no acknowledge follows.
- R7: An acknowledge cycle copies X into T[7:4] and P into T[3:0], then sets X=2, P=1 and `mie`=0. The changes are visible from the next cycle. `xp_ld` and `mie_ld` load X, P and `mie` from decode.
- R8: R0 increments by one (modulo 2^16) at the end of each DMA cycle and changes in no other way except through `r0_ld`.
- R9: `flags` takes the value of `ef` at the end of each fetch cycle and holds it otherwise.
- R10: An `idle_cmd` sampled at `tpb` of an execute cycle enters idle at the end of that cycle, unless a request was chosen for service. In idle, `idle` and `bus_float` are 1, `mrd_n` is 1, `state_code` stays 1, and no `tpa` or `tpb` pulse occurs.
- R11: Idle ends on live requests. A DMA request starts a DMA cycle, with DMA-in ahead of DMA-out ahead of interrupt. An interrupt request starts an acknowledge cycle when `mie` is 1, or a fetch cycle when `mie` is 0.
- R12: After reset: fetch cycle at clock 0, X=P=0, T=0, R0=0, `mie`=1, `flags`=0, not idle.
- R13: `mrd_n` is 0 during fetch, during DMA-out cycles and during execute while `exec_rd` is 1. It is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_in_req | input | 1 | DMA request, I/O to memory |
| dma_out_req | input | 1 | DMA request, memory to I/O |
| int_req | input | 1 | Interrupt request (level) |
| ef | input | FLAG_W | External status flag inputs |
| idle_cmd | input | 1 | Decode: current instruction is idle |
| exec_rd | input | 1 | Decode: execute cycle reads memory |
| xp_ld | input | 1 | Load X and P from decode |
| x_din | input | DES_W | New X value |
| p_din | input | DES_W | New P value |
| mie_ld | input | 1 | Load interrupt enable |
| mie_din | input | 1 | New interrupt enable value |
| r0_ld | input | 1 | Load DMA pointer |
| r0_din | input | ADDR_W | New DMA pointer value |
| state_code | output | 2 | Current cycle kind |
| tpa | output | 1 | Early timing pulse |
| tpb | output | 1 | Late timing pulse |
| mrd_n | output | 1 | Memory read strobe, active low |
| bus_float | output | 1 | Data bus must be released |
| idle | output | 1 | Idle mode active |
| dma_dir | output | 1 | Direction of current/last DMA cycle (1 = in) |
| x | output | DES_W | X designator |
| p | output | DES_W | P designator |
| t | output | 2*DES_W | Saved X,P |
| mie | output | 1 | Master interrupt enable |
| r0 | output | ADDR_W | DMA pointer |
| flags | output | FLAG_W | Flags captured at end of fetch |

## Verification
Some rules are checked on every cycle: the fixed spacing from `tpa` to `tpb`, execute after every fetch, the quiet outputs in idle, R0 moving only by a DMA step or a load, the context values after an acknowledge, and flags changing only after a fetch. The bench scenarios are the only place that shows the rest. They cover which request wins at a boundary, that requests outside the sampling points leave no trace, that an interrupt dropped during DMA is lost, and how idle is entered, refused while a service is pending, and left by each kind of request.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;
    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_EXEC  = 2'b01,
        CYC_DMA   = 2'b10,
        CYC_INTA  = 2'b11
    } cyc_e;
endpackage

// File: rtl/seq_phase_timer.sv
// Clock counter inside a machine cycle; frozen while idle.
module seq_phase_timer #(
    parameter int CYC_CLKS = 8,
    parameter int TPA_AT   = 1,
    parameter int TPB_AT   = 6,
    localparam int CNT_W   = $clog2(CYC_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tpa,
    output logic tpb,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYC_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!hold) begin
            if (tmr_q.cnt == LAST_CNT) tmr_d.cnt = '0;
            else                       tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tpa  = (tmr_q.cnt == CNT_W'(TPA_AT));
    assign tpb  = (tmr_q.cnt == CNT_W'(TPB_AT));
    assign last = (tmr_q.cnt == LAST_CNT) && !hold;
endmodule

// File: rtl/seq_req_arbiter.sv
// Samples requests at the late pulse, resolves priority at the cycle end,
// and resolves live requests for leaving idle.
module seq_req_arbiter
    import cyc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cyc_e cyc,
    input  logic tpb,
    input  logic last,
    input  logic dma_in_req,
    input  logic dma_out_req,
    input  logic int_req,
    input  logic mie,
    input  logic idle_cmd,
    output logic svc_valid,
    output cyc_e svc_cyc,
    output logic svc_dir,
    output logic go_idle,
    output logic wake_valid,
    output cyc_e wake_cyc,
    output logic wake_dir
);
    typedef struct packed {
        logic din;
        logic dout;
        logic irq;
        logic idl;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tpb) begin
            if (cyc != CYC_FETCH) begin
                smp_d.din  = dma_in_req;
                smp_d.dout = dma_out_req;
            end
            if (cyc == CYC_EXEC || cyc == CYC_DMA) smp_d.irq = int_req;
            if (cyc == CYC_EXEC)                   smp_d.idl = idle_cmd;
        end
        if (last) smp_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    // Boundary choice from sampled requests
    always_comb begin
        svc_valid = 1'b1;
        svc_cyc   = CYC_DMA;
        svc_dir   = 1'b0;
        if (smp_q.din) begin
            svc_dir = 1'b1;
        end else if (smp_q.dout) begin
            svc_dir = 1'b0;
        end else if (smp_q.irq && mie) begin
            svc_cyc = CYC_INTA;
        end else begin
            svc_valid = 1'b0;
            svc_cyc   = CYC_FETCH;
        end
    end

    assign go_idle = smp_q.idl && !svc_valid && (cyc == CYC_EXEC);

    // Wake-up choice from live requests
    always_comb begin
        wake_valid = dma_in_req || dma_out_req || int_req;
        wake_dir   = dma_in_req;
        if (dma_in_req || dma_out_req) wake_cyc = CYC_DMA;
        else if (mie)                  wake_cyc = CYC_INTA;
        else                           wake_cyc = CYC_FETCH;
    end
endmodule

// File: rtl/seq_context_regs.sv
// X, P, T, interrupt enable and DMA pointer.
module seq_context_regs #(
    parameter int DES_W  = 4,
    parameter int ADDR_W = 16,
    parameter int INT_X  = 2,
    parameter int INT_P  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_done,
    input  logic              dma_done,
    input  logic              xp_ld,
    input  logic [DES_W-1:0]  x_din,
    input  logic [DES_W-1:0]  p_din,
    input  logic              mie_ld,
    input  logic              mie_din,
    input  logic              r0_ld,
    input  logic [ADDR_W-1:0] r0_din,
    output logic [DES_W-1:0]  x,
    output logic [DES_W-1:0]  p,
    output logic [2*DES_W-1:0] t,
    output logic              mie,
    output logic [ADDR_W-1:0] r0
);
    typedef struct packed {
        logic [DES_W-1:0]   x;
        logic [DES_W-1:0]   p;
        logic [2*DES_W-1:0] t;
        logic               mie;
        logic [ADDR_W-1:0]  r0;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (xp_ld) begin
            ctx_d.x = x_din;
            ctx_d.p = p_din;
        end
        if (mie_ld) ctx_d.mie = mie_din;
        if (r0_ld)  ctx_d.r0  = r0_din;
        if (dma_done) ctx_d.r0 = ctx_q.r0 + 1'b1;
        if (int_done) begin
            ctx_d.t   = {ctx_q.x, ctx_q.p};
            ctx_d.x   = DES_W'(INT_X);
            ctx_d.p   = DES_W'(INT_P);
            ctx_d.mie = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            ctx_q.mie <= 1'b1;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign x   = ctx_q.x;
    assign p   = ctx_q.p;
    assign t   = ctx_q.t;
    assign mie = ctx_q.mie;
    assign r0  = ctx_q.r0;
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
    import cyc_seq_pkg::*;
#(
    parameter int CYC_CLKS = 8,
    parameter int TPA_AT   = 1,
    parameter int TPB_AT   = 6,
    parameter int DES_W    = 4,
    parameter int ADDR_W   = 16,
    parameter int FLAG_W   = 4,
    parameter int INT_X    = 2,
    parameter int INT_P    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_in_req,
    input  logic               dma_out_req,
    input  logic               int_req,
    input  logic [FLAG_W-1:0]  ef,
    input  logic               idle_cmd,
    input  logic               exec_rd,
    input  logic               xp_ld,
    input  logic [DES_W-1:0]   x_din,
    input  logic [DES_W-1:0]   p_din,
    input  logic               mie_ld,
    input  logic               mie_din,
    input  logic               r0_ld,
    input  logic [ADDR_W-1:0]  r0_din,
    output logic [1:0]         state_code,
    output logic               tpa,
    output logic               tpb,
    output logic               mrd_n,
    output logic               bus_float,
    output logic               idle,
    output logic               dma_dir,
    output logic [DES_W-1:0]   x,
    output logic [DES_W-1:0]   p,
    output logic [2*DES_W-1:0] t,
    output logic               mie,
    output logic [ADDR_W-1:0]  r0,
    output logic [FLAG_W-1:0]  flags
);
    typedef struct packed {
        cyc_e              cyc;
        logic              dir;
        logic              idle;
        logic [FLAG_W-1:0] flags;
    } seq_t;

    seq_t seq_d, seq_q;

    logic last;
    logic svc_valid, svc_dir, go_idle, wake_valid, wake_dir;
    cyc_e svc_cyc, wake_cyc;
    logic int_done, dma_done;

    seq_phase_timer #(
        .CYC_CLKS (CYC_CLKS),
        .TPA_AT   (TPA_AT),
        .TPB_AT   (TPB_AT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (seq_q.idle),
        .tpa   (tpa),
        .tpb   (tpb),
        .last  (last)
    );

    seq_req_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc         (seq_q.cyc),
        .tpb         (tpb),
        .last        (last),
        .dma_in_req  (dma_in_req),
        .dma_out_req (dma_out_req),
        .int_req     (int_req),
        .mie         (mie),
        .idle_cmd    (idle_cmd),
        .svc_valid   (svc_valid),
        .svc_cyc     (svc_cyc),
        .svc_dir     (svc_dir),
        .go_idle     (go_idle),
        .wake_valid  (wake_valid),
        .wake_cyc    (wake_cyc),
        .wake_dir    (wake_dir)
    );

    assign int_done = last && (seq_q.cyc == CYC_INTA);
    assign dma_done = last && (seq_q.cyc == CYC_DMA);

    seq_context_regs #(
        .DES_W  (DES_W),
        .ADDR_W (ADDR_W),
        .INT_X  (INT_X),
        .INT_P  (INT_P)
    ) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_done (int_done),
        .dma_done (dma_done),
        .xp_ld    (xp_ld),
        .x_din    (x_din),
        .p_din    (p_din),
        .mie_ld   (mie_ld),
        .mie_din  (mie_din),
        .r0_ld    (r0_ld),
        .r0_din   (r0_din),
        .x        (x),
        .p        (p),
        .t        (t),
        .mie      (mie),
        .r0       (r0)
    );

    always_comb begin
        seq_d = seq_q;
        if (seq_q.idle) begin
            if (wake_valid) begin
                seq_d.idle = 1'b0;
                seq_d.cyc  = wake_cyc;
                seq_d.dir  = wake_dir;
            end
        end else if (last) begin
            if (seq_q.cyc == CYC_FETCH) begin
                seq_d.flags = ef;
                seq_d.cyc   = CYC_EXEC;
            end else if (svc_valid) begin
                seq_d.cyc = svc_cyc;
                seq_d.dir = svc_dir;
            end else if (go_idle) begin
                seq_d.idle = 1'b1;
            end else begin
                seq_d.cyc = CYC_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.cyc <= CYC_FETCH;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        mrd_n = 1'b1;
        if (!seq_q.idle) begin
            case (seq_q.cyc)
                CYC_FETCH: mrd_n = 1'b0;
                CYC_EXEC:  mrd_n = !exec_rd;
                CYC_DMA:   mrd_n = seq_q.dir;
                default:   mrd_n = 1'b1;
            endcase
        end
    end

    assign state_code = seq_q.cyc;
    assign idle       = seq_q.idle;
    assign bus_float  = seq_q.idle;
    assign dma_dir    = seq_q.dir;
    assign flags      = seq_q.flags;
endmodule

// File: rtl/cycle_sequencer_chk.sv
module cycle_sequencer_chk #(
    parameter int TPA_AT = 1,
    parameter int TPB_AT = 6,
    parameter int DES_W  = 4,
    parameter int ADDR_W = 16,
    parameter int FLAG_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         state_code,
    input logic               tpa,
    input logic               tpb,
    input logic               mrd_n,
    input logic               bus_float,
    input logic               idle,
    input logic               r0_ld,
    input logic [DES_W-1:0]   x,
    input logic [DES_W-1:0]   p,
    input logic               mie,
    input logic [ADDR_W-1:0]  r0,
    input logic [FLAG_W-1:0]  flags
);
    localparam logic [7:0] GAP = 8'(TPB_AT - TPA_AT - 1);

    logic [7:0] since_tpa;
    logic       seen_tpa;
    logic [1:0] prev_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_tpa <= '0;
            seen_tpa  <= 1'b0;
            prev_code <= '0;
        end else if (tpa) begin
            since_tpa <= '0;
            seen_tpa  <= 1'b1;
            prev_code <= state_code;
        end else if (since_tpa != 8'hFF) begin
            since_tpa <= since_tpa + 1'b1;
        end
    end

    // R1
    a_r1_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tpb |-> (seen_tpa && since_tpa == GAP));
    a_r1_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tpa && tpb));
    // R3
    a_r3_exec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (tpa && seen_tpa && prev_code == 2'd0) |-> state_code == 2'd1);
    // R7
    a_r7_ack_context: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_code) == 2'd3 && state_code != 2'd3) |->
            (x == DES_W'(2) && p == DES_W'(1) && !mie));
    // R8
    a_r8_r0_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(r0_ld) && r0 != $past(r0)) |->
            (r0 == $past(r0) + 1'b1 && $past(state_code) == 2'd2));
    // R9
    a_r9_flags_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != $past(flags)) |-> $past(state_code) == 2'd0);
    // R10
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!tpa && !tpb && mrd_n && bus_float && state_code == 2'd1));
endmodule

bind cycle_sequencer cycle_sequencer_chk #(
    .TPA_AT (TPA_AT),
    .TPB_AT (TPB_AT),
    .DES_W  (DES_W),
    .ADDR_W (ADDR_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_code (state_code),
    .tpa        (tpa),
    .tpb        (tpb),
    .mrd_n      (mrd_n),
    .bus_float  (bus_float),
    .idle       (idle),
    .r0_ld      (r0_ld),
    .x          (x),
    .p          (p),
    .mie        (mie),
    .r0         (r0),
    .flags      (flags)
);

// File: tb/sim_cycle_sequencer.sv
`timescale 1ns/1ps
module sim_cycle_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_in_req = 0, dma_out_req = 0, int_req = 0;
    logic [3:0]  ef = 0;
    logic        idle_cmd = 0, exec_rd = 0;
    logic        xp_ld = 0, mie_ld = 0, mie_din = 0, r0_ld = 0;
    logic [3:0]  x_din = 0, p_din = 0;
    logic [15:0] r0_din = 0;
    logic [1:0]  state_code;
    logic        tpa, tpb, mrd_n, bus_float, idle, dma_dir, mie;
    logic [3:0]  x, p, flags;
    logic [7:0]  t;
    logic [15:0] r0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cycle_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .int_req(int_req), .ef(ef), .idle_cmd(idle_cmd), .exec_rd(exec_rd),
        .xp_ld(xp_ld), .x_din(x_din), .p_din(p_din), .mie_ld(mie_ld), .mie_din(mie_din),
        .r0_ld(r0_ld), .r0_din(r0_din), .state_code(state_code), .tpa(tpa), .tpb(tpb),
        .mrd_n(mrd_n), .bus_float(bus_float), .idle(idle), .dma_dir(dma_dir),
        .x(x), .p(p), .t(t), .mie(mie), .r0(r0), .flags(flags)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next_tpa();
        int guard = 0;
        @(negedge clk);
        while (!tpa && guard < 64) begin
            @(negedge clk);
            guard++;
        end
        if (!tpa) check("R1", "tpa timeout", 0, 1);
    endtask

    task automatic sync_code(input int c);
        for (int i = 0; i < 6; i++) begin
            next_tpa();
            if (state_code == c) break;
        end
    endtask

    task automatic pulse_xp(input int xv, input int pv);
        @(negedge clk);
        xp_ld = 1; x_din = 4'(xv); p_din = 4'(pv);
        @(negedge clk);
        xp_ld = 0;
    endtask

    task automatic set_mie(input logic v);
        @(negedge clk);
        mie_ld = 1; mie_din = v;
        @(negedge clk);
        mie_ld = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12", "code", state_code, 0);
        check("R12", "mie", mie, 1);
        check("R12", "x/p", {x, p}, 0);
        check("R12", "t", t, 0);
        check("R12", "r0", r0, 0);
        check("R12", "idle", idle, 0);
        check("R13", "mrd_n fetch", mrd_n, 0);
    endtask

    task automatic t_timing();
        int n;
        sync_code(0);
        n = 0;
        do begin @(negedge clk); n++; end while (!tpb && n < 20);
        check("R1", "tpa to tpb clocks", n, 5);
        n = 0;
        do begin @(negedge clk); n++; end while (!tpa && n < 20);
        check("R1", "tpb to tpa clocks", n, 3);
        check("R2", "code after fetch", state_code, 1);
        next_tpa();
        check("R2", "code after exec", state_code, 0);
    endtask

    task automatic t_dma_in();
        int r0b;
        sync_code(1);
        r0b = r0;
        dma_in_req = 1;
        next_tpa();
        check("R5", "dma-in code", state_code, 2);
        check("R5", "dma-in dir", dma_dir, 1);
        check("R13", "mrd_n dma-in", mrd_n, 1);
        dma_in_req = 0;
        next_tpa();
        check("R5", "back to fetch", state_code, 0);
        check("R8", "r0 step", r0, (r0b + 1) & 16'hFFFF);
    endtask

    task automatic t_fetch_no_service();
        sync_code(0);
        dma_out_req = 1;
        next_tpa();
        check("R3", "exec after fetch", state_code, 1);
        next_tpa();
        check("R3", "dma after exec", state_code, 2);
        check("R5", "dma-out dir", dma_dir, 0);
        check("R13", "mrd_n dma-out", mrd_n, 0);
        dma_out_req = 0;
        next_tpa();
        check("R5", "fetch after dma", state_code, 0);
    endtask

    task automatic t_priority();
        pulse_xp(5, 3);
        sync_code(1);
        dma_in_req = 1; dma_out_req = 1; int_req = 1;
        next_tpa();
        check("R5", "in wins", {state_code, dma_dir}, {2'd2, 1'b1});
        dma_in_req = 0;
        next_tpa();
        check("R5", "out next", {state_code, dma_dir}, {2'd2, 1'b0});
        dma_out_req = 0;
        next_tpa();
        check("R5", "interrupt last", state_code, 3);
        int_req = 0;
        next_tpa();
        check("R5", "fetch after ack", state_code, 0);
        check("R7", "t saved", t, 8'h53);
        check("R7", "x forced", x, 2);
        check("R7", "p forced", p, 1);
        check("R7", "mie cleared", mie, 0);
    endtask

    task automatic t_int_gating();
        sync_code(1);
        int_req = 1;
        next_tpa();
        check("R4", "int masked by mie", state_code, 0);
        int_req = 0;
        set_mie(1);
        check("R7", "mie load", mie, 1);
        sync_code(0);
        int_req = 1;
        next_tpa();
        int_req = 0;
        next_tpa();
        check("R4", "int only in fetch ignored", state_code, 0);
        sync_code(0);
        dma_in_req = 1;
        next_tpa();
        dma_in_req = 0;
        next_tpa();
        check("R4", "dma only in fetch ignored", state_code, 0);
    endtask

    task automatic t_not_latched();
        sync_code(1);
        dma_in_req = 1; int_req = 1;
        next_tpa();
        check("R6", "dma first", state_code, 2);
        dma_in_req = 0; int_req = 0;
        next_tpa();
        check("R6", "dropped int lost", state_code, 0);
    endtask

    task automatic t_flags();
        sync_code(0);
        ef = 4'hA;
        next_tpa();
        check("R9", "flags captured", flags, 4'hA);
        ef = 4'h5;
        next_tpa();
        check("R9", "flags held", flags, 4'hA);
        next_tpa();
        check("R9", "flags recaptured", flags, 4'h5);
    endtask

    task automatic t_exec_rd();
        sync_code(1);
        exec_rd = 1;
        #0.1;
        check("R13", "mrd_n exec read", mrd_n, 0);
        exec_rd = 0;
        #0.1;
        check("R13", "mrd_n exec no read", mrd_n, 1);
    endtask

    task automatic t_r0_wrap();
        @(negedge clk);
        r0_ld = 1; r0_din = 16'hFFFF;
        @(negedge clk);
        r0_ld = 0;
        check("R8", "r0 load", r0, 16'hFFFF);
        sync_code(1);
        dma_in_req = 1;
        next_tpa();
        dma_in_req = 0;
        next_tpa();
        check("R8", "r0 wrap", r0, 0);
    endtask

    task automatic enter_idle();
        int g = 0;
        sync_code(1);
        idle_cmd = 1;
        while (!idle && g < 20) begin @(negedge clk); g++; end
        idle_cmd = 0;
        check("R10", "idle entered", idle, 1);
    endtask

    task automatic t_idle();
        int pulses = 0;
        enter_idle();
        check("R10", "bus_float", bus_float, 1);
        check("R10", "mrd_n idle", mrd_n, 1);
        check("R10", "code held", state_code, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tpa || tpb) pulses++;
        end
        check("R10", "no pulses in idle", pulses, 0);
        int_req = 1;
        next_tpa();
        check("R11", "int wakes to ack", state_code, 3);
        check("R11", "idle left", idle, 0);
        int_req = 0;
        set_mie(1);
        enter_idle();
        dma_out_req = 1; int_req = 1;
        next_tpa();
        check("R11", "dma beats int on wake", {state_code, dma_dir}, {2'd2, 1'b0});
        dma_out_req = 0; int_req = 0;
        set_mie(0);
        enter_idle();
        int_req = 1;
        next_tpa();
        check("R11", "masked int wakes to fetch", state_code, 0);
        int_req = 0;
        set_mie(1);
        sync_code(1);
        idle_cmd = 1; dma_in_req = 1;
        next_tpa();
        idle_cmd = 0; dma_in_req = 0;
        check("R10", "service overrides idle", {idle, state_code}, {1'b0, 2'd2});
        next_tpa();
        check("R10", "no late idle", {idle, state_code}, {1'b0, 2'd0});
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timing();
        t_dma_in();
        t_fetch_no_service();
        t_priority();
        t_int_gating();
        t_not_latched();
        t_flags();
        t_exec_rd();
        t_r0_wrap();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule